// File: doc/BRIEF.md
# Dual-Bus Bridge with Row Buffer

This block is the memory-side controller that sits between a 16-bit CPU bus and a 14-bit video bus. On both buses, address and data share the same lines. It works in one of two modes. In copy mode the CPU owns display memory. The bridge forwards the low 14 bits of whatever the CPU drives onto the video side, and it returns video-side read data to the CPU in the phases where a device is expected to answer.

In video mode the CPU side is cut off. The display engine's fill/read strobe then fetches one row of display words into a 20-entry buffer. For the next 15 scanlines that same row is replayed from the buffer, and display memory is not used during those lines. A row-start strobe marks the start of each scanline.

The bridge switches modes when it sees protocol events on the CPU bus. An interrupt-acknowledge phase opens the bridge into copy mode. A falling edge on the active-low bus-acknowledge line closes it again and starts a fresh row fill.

Top module: `dual_bus_bridge`

## Requirements
- R1: The phase code 111 (interrupt acknowledge) puts the block into copy mode, and `cpu_mode` reads 1 after that clock edge. The copy path is already active during the acknowledge cycle itself.
- R2: In copy mode, the phases 100, 101, 110 and 111 are CPU-driving phases. In those phases `vid_doe` is 1, `vid_dout` equals `cpu_din[13:0]` and `cpu_doe` is 0.
- R3: In copy mode, the phases 001 and 011 are device-answer phases. In those phases `cpu_doe` is 1 and `cpu_dout` is `vid_din` zero-extended to 16 bits. In phases 000 and 010 neither side drives.
- R4: A high-to-low transition of `busak_n` while in copy mode, with no acknowledge phase in the same cycle, returns the block to video mode at the next edge. If `busak_n` is held low without a new fall, the mode does not change.
- R5: On entry to video mode, the first 20 `fill_stb` pulses each store `vid_din` in the next buffer slot. Each pulse also presents that word on `row_q`, with `row_qv` high one cycle after the pulse.
- R6: After the fill, each of the next 15 rows starts with a `row_stb`. In those rows each `fill_stb` returns the stored word and `vid_din` is ignored. The `row_stb` after the 15th replayed row returns the block to filling.
- R7: During replay the read pointer returns to slot 0 on every `row_stb`. It advances on each `fill_stb` and wraps to slot 0 after slot 19.
- R8: In video mode, `cpu_doe` and `vid_doe` are both 0 for every phase code. In copy mode, `fill_stb` and `row_stb` have no effect and `row_qv` stays 0.
- R9: `err` is 1 in the cycle after one in which `vid_drive` was high while the copy path was active. Otherwise it is 0.
- R10: Reset leaves the block in video mode with an empty buffer, so the first `fill_stb` stores and shows `vid_din`. After reset all enables and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_phase | input | 3 | CPU bus phase code |
| cpu_din | input | 16 | Value driven on the CPU bus by the CPU |
| cpu_dout | output | 16 | Value the bridge drives onto the CPU bus |
| cpu_doe | output | 1 | Bridge drives the CPU bus |
| busak_n | input | 1 | Active-low bus acknowledge |
| fill_stb | input | 1 | Fill/read strobe from the video side |
| row_stb | input | 1 | Row-start strobe |
| vid_din | input | 14 | Data on the video bus from display memory |
| vid_drive | input | 1 | Video side is driving its bus |
| vid_dout | output | 14 | Value the bridge drives onto the video bus |
| vid_doe | output | 1 | Bridge drives the video bus |
| row_q | output | 14 | Row word delivered to the display engine |
| row_qv | output | 1 | `row_q` valid |
| cpu_mode | output | 1 | 1 in copy mode, 0 in video mode |
| err | output | 1 | Bus contention seen in the previous cycle |

## Verification
The in-RTL assertions check on every cycle that the two output enables never fight and that both are off whenever the copy path is idle. They also check that an acknowledge phase always lands in copy mode, that the mode holds between events, that contention raises `err`, and that the buffer pointers stay in range. Other behaviour can only be shown by the bench's scenarios. This includes the data a full 20-word fill returns across all 15 replayed rows, the pointer wrap in an over-long row, the return to filling after the last replay, and that a bus-acknowledge level without a new fall leaves the mode alone.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

    typedef enum logic [2:0] {
        PH_NACT  = 3'b000,
        PH_ADAR  = 3'b001,
        PH_IAB   = 3'b010,
        PH_DTB   = 3'b011,
        PH_BAR   = 3'b100,
        PH_DW    = 3'b101,
        PH_DWS   = 3'b110,
        PH_INTAK = 3'b111
    } phase_e;

    typedef enum logic {
        RB_FILL   = 1'b0,
        RB_REPLAY = 1'b1
    } rb_state_e;

    // Phases in which the CPU places a value on the shared lines
    function automatic logic cpu_drives(phase_e p);
        return (p == PH_BAR) || (p == PH_DW) || (p == PH_DWS) || (p == PH_INTAK);
    endfunction

    // Phases in which memory is expected to answer the CPU
    function automatic logic dev_answers(phase_e p);
        return (p == PH_ADAR) || (p == PH_DTB);
    endfunction

endpackage

// File: rtl/bbr_mode_ctl.sv
module bbr_mode_ctl
    import bbr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase,
    input  logic   busak_n,
    input  logic   vid_drive,
    output logic   mode_q,
    output logic   copy_act,
    output logic   enter_vid,
    output logic   err_q
);
    logic intak;
    logic busak_q;

    assign intak     = (phase == PH_INTAK);
    assign copy_act  = mode_q | intak;
    assign enter_vid = mode_q & ~intak & busak_q & ~busak_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            busak_q <= 1'b1;
            err_q   <= 1'b0;
        end else begin
            busak_q <= busak_n;
            err_q   <= copy_act & vid_drive;
            if (intak)
                mode_q <= 1'b1;
            else if (enter_vid)
                mode_q <= 1'b0;
        end
    end

    a_r1_intak_opens: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_INTAK) |=> mode_q);

    a_r4_hold_without_fall: assert property (@(posedge clk) disable iff (rst)
        (mode_q && phase != PH_INTAK && !(busak_q && !busak_n)) |=> mode_q);

    a_r4_fall_closes: assert property (@(posedge clk) disable iff (rst)
        (mode_q && phase != PH_INTAK && busak_q && !busak_n) |=> !mode_q);

endmodule

// File: rtl/bbr_copy_path.sv
module bbr_copy_path
    import bbr_pkg::*;
#(
    parameter int CPU_W = 16,
    parameter int VID_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             copy_act,
    input  phase_e           phase,
    input  logic [CPU_W-1:0] cpu_din,
    input  logic [VID_W-1:0] vid_din,
    output logic [CPU_W-1:0] cpu_dout,
    output logic             cpu_doe,
    output logic [VID_W-1:0] vid_dout,
    output logic             vid_doe
);
    localparam int PAD_W = CPU_W - VID_W;

    logic unused_hi_bits;
    assign unused_hi_bits = ^cpu_din[CPU_W-1:VID_W];

    assign vid_dout = cpu_din[VID_W-1:0];
    assign vid_doe  = copy_act & cpu_drives(phase);
    assign cpu_dout = {{PAD_W{1'b0}}, vid_din};
    assign cpu_doe  = copy_act & dev_answers(phase);

    a_r8_isolated: assert property (@(posedge clk) disable iff (rst)
        !copy_act |-> (!cpu_doe && !vid_doe));

    a_r3_no_fight: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_doe, vid_doe}));

endmodule

// File: rtl/bbr_row_buf.sv
module bbr_row_buf
    import bbr_pkg::*;
#(
    parameter int VID_W   = 14,
    parameter int DEPTH   = 20,
    parameter int REPLAYS = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic             fill_stb,
    input  logic             row_stb,
    input  logic [VID_W-1:0] vid_din,
    output logic [VID_W-1:0] row_q,
    output logic             row_qv
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int REP_W = $clog2(REPLAYS + 1);
    localparam logic [PTR_W-1:0] LAST    = PTR_W'(DEPTH - 1);
    localparam logic [REP_W-1:0] REP_MAX = REP_W'(REPLAYS);

    logic [VID_W-1:0] mem [DEPTH];
    rb_state_e        st;
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic [REP_W-1:0] reps;
    logic             do_write;

    assign do_write = en & ~restart & ~row_stb & fill_stb & (st == RB_FILL);

    always_ff @(posedge clk) begin
        if (do_write)
            mem[wptr] <= vid_din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RB_FILL;
            wptr   <= '0;
            rptr   <= '0;
            reps   <= '0;
            row_q  <= '0;
            row_qv <= 1'b0;
        end else begin
            row_qv <= 1'b0;
            if (restart) begin
                st   <= RB_FILL;
                wptr <= '0;
                rptr <= '0;
                reps <= '0;
            end else if (en) begin
                if (row_stb) begin
                    rptr <= '0;
                    if (st == RB_FILL) begin
                        wptr <= '0;
                    end else if (reps == REP_MAX) begin
                        st   <= RB_FILL;
                        wptr <= '0;
                        reps <= '0;
                    end else begin
                        reps <= reps + REP_W'(1);
                    end
                end else if (fill_stb) begin
                    row_qv <= 1'b1;
                    if (st == RB_FILL) begin
                        row_q <= vid_din;
                        if (wptr == LAST) begin
                            wptr <= '0;
                            rptr <= '0;
                            reps <= '0;
                            st   <= RB_REPLAY;
                        end else begin
                            wptr <= wptr + PTR_W'(1);
                        end
                    end else begin
                        row_q <= mem[rptr];
                        rptr  <= (rptr == LAST) ? '0 : rptr + PTR_W'(1);
                    end
                end
            end
        end
    end

    a_r7_ptrs_in_range: assert property (@(posedge clk) disable iff (rst)
        (32'(wptr) < DEPTH) && (32'(rptr) < DEPTH));

    a_r6_replays_bounded: assert property (@(posedge clk) disable iff (rst)
        32'(reps) <= REPLAYS);

    a_r7_row_start_zero: assert property (@(posedge clk) disable iff (rst)
        (en && !restart && row_stb) |=> (rptr == '0));

    a_r5_fill_passes: assert property (@(posedge clk) disable iff (rst)
        (en && !restart && !row_stb && fill_stb && st == RB_FILL)
            |=> (row_qv && row_q == $past(vid_din)));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |=> !row_qv);

endmodule

// File: rtl/dual_bus_bridge.sv
module dual_bus_bridge
    import bbr_pkg::*;
#(
    parameter int CPU_W   = 16,
    parameter int VID_W   = 14,
    parameter int DEPTH   = 20,
    parameter int REPLAYS = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       cpu_phase,
    input  logic [CPU_W-1:0] cpu_din,
    output logic [CPU_W-1:0] cpu_dout,
    output logic             cpu_doe,
    input  logic             busak_n,
    input  logic             fill_stb,
    input  logic             row_stb,
    input  logic [VID_W-1:0] vid_din,
    input  logic             vid_drive,
    output logic [VID_W-1:0] vid_dout,
    output logic             vid_doe,
    output logic [VID_W-1:0] row_q,
    output logic             row_qv,
    output logic             cpu_mode,
    output logic             err
);
    phase_e phase;
    logic   copy_act;
    logic   enter_vid;

    assign phase = phase_e'(cpu_phase);

    bbr_mode_ctl i_mode (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .busak_n   (busak_n),
        .vid_drive (vid_drive),
        .mode_q    (cpu_mode),
        .copy_act  (copy_act),
        .enter_vid (enter_vid),
        .err_q     (err)
    );

    bbr_copy_path #(.CPU_W(CPU_W), .VID_W(VID_W)) i_copy (
        .clk      (clk),
        .rst      (rst),
        .copy_act (copy_act),
        .phase    (phase),
        .cpu_din  (cpu_din),
        .vid_din  (vid_din),
        .cpu_dout (cpu_dout),
        .cpu_doe  (cpu_doe),
        .vid_dout (vid_dout),
        .vid_doe  (vid_doe)
    );

    bbr_row_buf #(.VID_W(VID_W), .DEPTH(DEPTH), .REPLAYS(REPLAYS)) i_rbuf (
        .clk      (clk),
        .rst      (rst),
        .en       (~copy_act),
        .restart  (enter_vid),
        .fill_stb (fill_stb),
        .row_stb  (row_stb),
        .vid_din  (vid_din),
        .row_q    (row_q),
        .row_qv   (row_qv)
    );

    a_r9_contention_flag: assert property (@(posedge clk) disable iff (rst)
        (cpu_mode && vid_drive) |=> err);

endmodule

// File: tb/test_dual_bus_bridge.sv
module test_dual_bus_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cpu_phase = 3'b000;
    logic [15:0] cpu_din = '0;
    logic [15:0] cpu_dout;
    logic        cpu_doe;
    logic        busak_n = 1'b1;
    logic        fill_stb = 1'b0;
    logic        row_stb = 1'b0;
    logic [13:0] vid_din = '0;
    logic        vid_drive = 1'b0;
    logic [13:0] vid_dout;
    logic        vid_doe;
    logic [13:0] row_q;
    logic        row_qv;
    logic        cpu_mode;
    logic        err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dual_bus_bridge i_dual_bus_bridge (
        .clk(clk), .rst(rst), .cpu_phase(cpu_phase), .cpu_din(cpu_din),
        .cpu_dout(cpu_dout), .cpu_doe(cpu_doe), .busak_n(busak_n),
        .fill_stb(fill_stb), .row_stb(row_stb), .vid_din(vid_din),
        .vid_drive(vid_drive), .vid_dout(vid_dout), .vid_doe(vid_doe),
        .row_q(row_q), .row_qv(row_qv), .cpu_mode(cpu_mode), .err(err)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] word(int row, int i);
        return 14'((row * 37 + i * 5 + 1) & 16'h3fff);
    endfunction

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R10 reset state
        chk("R10 mode", cpu_mode, 0);
        chk("R10 err", err, 0);
        chk("R10 cpu_doe", cpu_doe, 0);
        chk("R10 vid_doe", vid_doe, 0);
        chk("R10 row_qv", row_qv, 0);

        // R5 / R10: fill a full row from an empty buffer
        for (int i = 0; i < 20; i++) begin
            fill_stb = 1'b1; vid_din = word(0, i);
            step();
            chk("R5 valid", row_qv, 1);
            chk("R5 fill data", row_q, word(0, i));
        end
        fill_stb = 1'b0;

        // R6 / R7: 15 replayed rows, video data ignored; first row over-long to wrap
        for (int r = 1; r <= 15; r++) begin
            row_stb = 1'b1; step(); row_stb = 1'b0;
            for (int i = 0; i < ((r == 1) ? 21 : 20); i++) begin
                fill_stb = 1'b1; vid_din = 14'h3fff ^ 14'(i * 3 + r);
                step();
                chk((i == 20) ? "R7 wrap" : "R6 replay", row_q, word(0, i % 20));
            end
            fill_stb = 1'b0;
        end
        // R6: next row start goes back to filling
        row_stb = 1'b1; step(); row_stb = 1'b0;
        for (int i = 0; i < 5; i++) begin
            fill_stb = 1'b1; vid_din = word(1, i);
            step();
            chk("R6 refill", row_q, word(1, i));
        end
        fill_stb = 1'b0;

        // R8: video mode isolation over all non-acknowledge phases
        for (int p = 0; p < 7; p++) begin
            cpu_phase = 3'(p); cpu_din = 16'(p * 4099 + 7); vid_din = 14'(p * 611);
            #1;
            chk("R8 cpu_doe", cpu_doe, 0);
            chk("R8 vid_doe", vid_doe, 0);
        end
        cpu_phase = 3'b000;
        vid_drive = 1'b1; step(); vid_drive = 1'b0;
        chk("R9 no err in video", err, 0);

        // R1: acknowledge opens copy path in the same cycle
        cpu_phase = 3'b111; cpu_din = 16'habcd;
        #1;
        chk("R1 same-cycle vid_doe", vid_doe, 1);
        chk("R1 same-cycle data", vid_dout, 16'habcd & 16'h3fff);
        step();
        cpu_phase = 3'b000;
        chk("R1 mode", cpu_mode, 1);

        // R2 / R3: phase and data sweep in copy mode
        for (int p = 0; p < 8; p++) begin
            for (int k = 0; k < 4; k++) begin
                logic drv, ans;
                cpu_phase = 3'(p);
                cpu_din = 16'(p * 4099 + k * 12345);
                vid_din = 14'(p * 1111 + k * 2345);
                #1;
                drv = (p >= 4);
                ans = (p == 1) || (p == 3);
                chk("R2 vid_doe", vid_doe, drv);
                if (drv) chk("R2 vid data", vid_dout, cpu_din & 16'h3fff);
                chk("R3 cpu_doe", cpu_doe, ans);
                if (ans) chk("R3 cpu data", cpu_dout, 32'(vid_din));
            end
        end
        cpu_phase = 3'b000;
        step();

        // R8: strobes ignored in copy mode
        fill_stb = 1'b1; step(); chk("R8 fill ignored", row_qv, 0);
        fill_stb = 1'b0; row_stb = 1'b1; step(); chk("R8 row ignored", row_qv, 0);
        row_stb = 1'b0;

        // R9: contention flag
        vid_drive = 1'b1; step(); vid_drive = 1'b0;
        chk("R9 err set", err, 1);
        step();
        chk("R9 err clear", err, 0);

        // R4: falling bus acknowledge closes, buffer restarts empty
        busak_n = 1'b0; step();
        chk("R4 closed", cpu_mode, 0);
        fill_stb = 1'b1; vid_din = 14'h1a5a; step(); fill_stb = 1'b0;
        chk("R4 restart fill", row_q, 14'h1a5a);

        // R4: low level without new fall keeps copy mode
        cpu_phase = 3'b111; step(); cpu_phase = 3'b000;
        chk("R4 reopened", cpu_mode, 1);
        repeat (3) step();
        chk("R4 level holds", cpu_mode, 1);
        busak_n = 1'b1; step();
        busak_n = 1'b0; step();
        chk("R4 second fall", cpu_mode, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule